// File: doc/BRIEF.md
# Dual Programmable Blink Rate Generator

This block makes two independent blink waveforms for an LED output selector. Each channel takes two 8-bit settings. The prescale setting fixes how long one blink period lasts. The duty setting fixes what part of that period the output spends in its active (LED on) phase.

All channels share one timebase. A parameterised divider turns the system clock into a tick that arrives 38 × 256 times per second. Each blink period has 256 equal steps, and each step lasts (prescale + 1) ticks. The period is therefore (prescale + 1)/38 seconds. That gives about 38 Hz at prescale 0 and about 0.148 Hz at prescale 255.

A channel holds an active copy of its two settings and refreshes that copy only at the end of a period. Software can rewrite the inputs at any time without cutting a pulse short. A simulation parameter replaces the derived divide ratio so that tests can run with short periods.

Top module: `dual_blink_gen`

## Requirements
- R1: While reset is held, every blink output is 0. After reset the active prescale and duty of each channel are both zero, so every output stays 0 for the first full period of 256 ticks, whatever the inputs are.
- R2: With a steady prescale P, the time from one rising edge of a channel's output to the next is 256 × (P + 1) ticks. At P = 0 this is 256 ticks.
- R3: With a steady prescale P and a nonzero duty D, each active pulse lasts D × (P + 1) ticks and begins at the start of a period.
- R4: A duty value of 0 keeps the output at 0 for the whole period.
- R5: New prescale and duty input values are taken up only at a period boundary. A pulse already under way keeps the width and period of the settings that were active when it began. An output rises only in the cycle that follows a period boundary.
- R6: The channels are independent. Channel n reads its prescale from psc_i[8n+7:8n] and its duty from duty_i[8n+7:8n], and drives blink_o[n]. The settings of one channel never change the timing of another.
- R7: One tick occurs every TICK_DIV clock cycles. TICK_DIV equals SIM_DIV when SIM_DIV is greater than 0. Otherwise it is CLK_HZ / (38 × 256), with a minimum of 1. Outputs change only in the cycle after a tick.
- R8: A duty value of 255 gives an inactive phase of exactly one step, (P + 1) ticks, at the end of each period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| psc_i | input | NUM_CH*8 | Prescale setting per channel; channel n in bits [8n+7:8n] |
| duty_i | input | NUM_CH*8 | Duty setting per channel; channel n in bits [8n+7:8n] |
| blink_o | output | NUM_CH | Blink waveform per channel, 1 = active (LED on) |

## Verification
The hardest case to reach from the ports is a settings change that arrives in the middle of a pulse. The bench must then show that the current pulse keeps its old width and period and that the next pulse uses the new values. To reach it, the bench waits for a rising edge, rewrites both settings a few cycles later, and measures two back-to-back pulses. The first boundary after reset is a second hard case, because the outputs must stay dark even though the inputs are already nonzero. The bench loads nonzero inputs before releasing reset and confirms that no edge appears before the first boundary. Random prescale and duty pairs for both channels run at the same time, so each channel's timing is checked while the other runs with different settings.

// File: rtl/blink_pkg.sv
package blink_pkg;

  localparam int SET_W          = 8;
  localparam int STEP_W         = 8;
  localparam int STEPS_PER_PER  = 1 << STEP_W;
  localparam int BASE_RATE_HZ   = 38;

  typedef struct packed {
    logic [SET_W-1:0] psc;
    logic [SET_W-1:0] duty;
  } blink_cfg_t;

  // Clock cycles per timebase tick for a given clock frequency, at least 1.
  function automatic int calc_tick_div(input int clk_hz);
    int d;
    d = clk_hz / (BASE_RATE_HZ * STEPS_PER_PER);
    if (d < 1) d = 1;
    return d;
  endfunction

endpackage

// File: rtl/blink_rst_sync.sv
module blink_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);

  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];

endmodule

// File: rtl/blink_timebase.sv
module blink_timebase #(
  parameter int TICK_DIV = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);

  localparam int CNT_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_DIV - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wrap;

  always_comb begin
    wrap  = (cnt_q == LAST);
    cnt_d = wrap ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = wrap;

endmodule

// File: rtl/blink_channel.sv
module blink_channel
  import blink_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  blink_cfg_t cfg_i,
  output logic       blink_o,
  output logic       bound_o
);

  localparam logic [STEP_W-1:0] LAST_STEP = '1;

  logic [SET_W-1:0]  rep_q, rep_d;
  logic [STEP_W-1:0] step_q, step_d;
  blink_cfg_t        act_q, act_d;
  logic              blink_q, blink_d;
  logic              step_end;

  // Next-state: repeat counter spans one step, step counter spans one period.
  always_comb begin
    rep_d    = rep_q;
    step_d   = step_q;
    act_d    = act_q;
    step_end = (rep_q == act_q.psc);
    bound_o  = tick_i & step_end & (step_q == LAST_STEP);
    if (step_end) begin
      rep_d  = '0;
      step_d = step_q + 1'b1;
      if (step_q == LAST_STEP) act_d = cfg_i;
    end else begin
      rep_d = rep_q + 1'b1;
    end
    blink_d = (step_d < act_d.duty);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rep_q   <= '0;
      step_q  <= '0;
      act_q   <= '0;
      blink_q <= 1'b0;
    end else if (tick_i) begin
      rep_q   <= rep_d;
      step_q  <= step_d;
      act_q   <= act_d;
      blink_q <= blink_d;
    end
  end

  assign blink_o = blink_q;

endmodule

// File: rtl/dual_blink_gen.sv
module dual_blink_gen
  import blink_pkg::*;
#(
  parameter int NUM_CH  = 2,
  parameter int CLK_HZ  = 50_000_000,
  parameter int SIM_DIV = 0
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [NUM_CH*SET_W-1:0] psc_i,
  input  logic [NUM_CH*SET_W-1:0] duty_i,
  output logic [NUM_CH-1:0]       blink_o
);

  localparam int TICK_DIV = (SIM_DIV > 0) ? SIM_DIV : calc_tick_div(CLK_HZ);

  logic              rst_sync_n;
  logic              tick;
  logic [NUM_CH-1:0] bound;

  blink_rst_sync u_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  blink_timebase #(.TICK_DIV(TICK_DIV)) u_timebase (
    .clk_i  (clk_i),
    .rst_ni (rst_sync_n),
    .tick_o (tick)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    blink_cfg_t cfg;
    assign cfg.psc  = psc_i[c*SET_W +: SET_W];
    assign cfg.duty = duty_i[c*SET_W +: SET_W];

    blink_channel u_chan (
      .clk_i   (clk_i),
      .rst_ni  (rst_sync_n),
      .tick_i  (tick),
      .cfg_i   (cfg),
      .blink_o (blink_o[c]),
      .bound_o (bound[c])
    );
  end

endmodule

// File: rtl/dual_blink_chk.sv
module dual_blink_chk #(
  parameter int NUM_CH   = 2,
  parameter int TICK_DIV = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  tick_i,
  input logic [NUM_CH-1:0]     bound_i,
  input logic [NUM_CH*8-1:0]   duty_i,
  input logic [NUM_CH-1:0]     blink_i
);

  logic [31:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     gap_q <= '0;
    else if (tick_i) gap_q <= '0;
    else             gap_q <= gap_q + 1;
  end

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) rst_quiet_chk: assert (blink_i == '0);
  end

  // R7
  tick_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |-> (gap_q == 32'(TICK_DIV - 1)));

  // R7
  hold_between_ticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(tick_i) |-> $stable(blink_i));

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R5
    rise_at_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(blink_i[c]) |-> $past(bound_i[c]));

    // R4
    duty_zero_dark_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(blink_i[c]) |-> ($past(duty_i[c*8 +: 8]) != 8'd0));
  end

endmodule

bind dual_blink_gen dual_blink_chk #(
  .NUM_CH   (NUM_CH),
  .TICK_DIV (TICK_DIV)
) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .tick_i  (tick),
  .bound_i (bound),
  .duty_i  (duty_i),
  .blink_i (blink_o)
);

// File: tb/dual_blink_gen_tb.sv
module dual_blink_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int NCH        = 2;
  localparam int LIMIT      = 40000;

  logic             clk = 1'b0;
  logic             rst_n;
  logic [NCH*8-1:0] psc_v;
  logic [NCH*8-1:0] duty_v;
  logic [NCH-1:0]   blink;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_blink_gen #(.NUM_CH(NCH), .CLK_HZ(50_000_000), .SIM_DIV(DIV)) u_dut (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .psc_i   (psc_v),
    .duty_i  (duty_v),
    .blink_o (blink)
  );

  function automatic int exp_period(input int psc);
    return 256 * (psc + 1) * DIV;
  endfunction

  function automatic int exp_high(input int psc, input int duty);
    return duty * (psc + 1) * DIV;
  endfunction

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg(input int ch, input int psc, input int duty);
    psc_v[ch*8 +: 8]  = psc[7:0];
    duty_v[ch*8 +: 8] = duty[7:0];
  endtask

  task automatic wait_rise(input int ch, input int limit, output bit found);
    logic prev;
    prev  = blink[ch];
    found = 1'b0;
    for (int n = 0; n < limit; n++) begin
      @(negedge clk);
      if (!prev && blink[ch]) begin
        found = 1'b1;
        break;
      end
      prev = blink[ch];
    end
  endtask

  // Called at the negedge where a rise was seen; returns at the next rise.
  task automatic measure_pulse(input int ch, output int hi, output int per);
    bit low_seen;
    hi = 1; per = 1; low_seen = 1'b0;
    for (int n = 0; n < LIMIT; n++) begin
      @(negedge clk);
      if (blink[ch]) begin
        if (low_seen) break;
        hi++;
      end else begin
        low_seen = 1'b1;
      end
      per++;
    end
  endtask

  task automatic grab(input int ch, output bit found, output int hi, output int per);
    hi = 0; per = 0;
    wait_rise(ch, LIMIT, found);
    if (found) measure_pulse(ch, hi, per);
  endtask

  task automatic run_both(input int p0, input int d0, input int p1, input int d1, input string tag);
    bit f0, f1;
    int h0, h1, q0, q1;
    set_cfg(0, p0, d0);
    set_cfg(1, p1, d1);
    fork
      grab(0, f0, h0, q0);
      grab(1, f1, h1, q1);
    join
    check_eq("R6", {tag, " ch0 rise"}, int'(f0), 1);
    check_eq("R6", {tag, " ch1 rise"}, int'(f1), 1);
    check_eq("R2", {tag, " ch0 period"}, q0, exp_period(p0));
    check_eq("R3", {tag, " ch0 high"}, h0, exp_high(p0, d0));
    check_eq("R2", {tag, " ch1 period"}, q1, exp_period(p1));
    check_eq("R3", {tag, " ch1 high"}, h1, exp_high(p1, d1));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    bit f;
    int hi, per, highs;
    rst_n  = 1'b0;
    psc_v  = '0;
    duty_v = '0;
    set_cfg(0, 1, 64);
    set_cfg(1, 2, 200);
    repeat (5) @(negedge clk);
    check_eq("R1", "output during reset", int'(blink), 0);
    rst_n = 1'b1;

    // R1: zero settings active for the first period despite nonzero inputs
    highs = 0;
    for (int n = 0; n < 250 * DIV; n++) begin
      @(negedge clk);
      if (blink != '0) highs++;
    end
    check_eq("R1", "dark first period", highs, 0);
    begin
      bit f0, f1;
      int h0, h1, q0, q1;
      fork
        begin wait_rise(0, 40 * DIV, f0); if (f0) measure_pulse(0, h0, q0); end
        begin wait_rise(1, 40 * DIV, f1); if (f1) measure_pulse(1, h1, q1); end
      join
      check_eq("R1", "ch0 rises at first boundary", int'(f0), 1);
      check_eq("R1", "ch1 rises at first boundary", int'(f1), 1);
      check_eq("R2", "ch0 first period", q0, exp_period(1));
      check_eq("R3", "ch0 first high", h0, exp_high(1, 64));
      check_eq("R6", "ch1 first period", q1, exp_period(2));
      check_eq("R6", "ch1 first high", h1, exp_high(2, 200));
    end

    // R2 R3 R6 R7: random settings on both channels at once
    void'($urandom(32'd2024));
    for (int t = 0; t < 8; t++) begin
      int p0, p1, d0, d1;
      p0 = int'($urandom_range(5, 0));
      p1 = int'($urandom_range(5, 0));
      d0 = int'($urandom_range(255, 1));
      d1 = int'($urandom_range(255, 1));
      run_both(p0, d0, p1, d1, $sformatf("R7 rnd%0d", t));
    end

    // R2 shortest period, R8 full duty
    run_both(0, 1, 2, 255, "edge");
    set_cfg(0, 2, 255);
    grab(0, f, hi, per);
    check_eq("R8", "duty 255 low phase", per - hi, (2 + 1) * DIV);

    // R5: change settings in the middle of a pulse
    set_cfg(0, 3, 100);
    grab(0, f, hi, per);
    check_eq("R5", "setup rise", int'(f), 1);
    fork
      measure_pulse(0, hi, per);
      begin repeat (5) @(negedge clk); set_cfg(0, 1, 40); end
    join
    check_eq("R5", "pulse keeps old high", hi, exp_high(3, 100));
    check_eq("R5", "pulse keeps old period", per, exp_period(3));
    measure_pulse(0, hi, per);
    check_eq("R5", "next pulse new high", hi, exp_high(1, 40));
    check_eq("R5", "next pulse new period", per, exp_period(1));

    // R4 with R6: duty 0 on ch0 while ch1 keeps running
    set_cfg(0, 0, 0);
    set_cfg(1, 0, 128);
    repeat (2 * exp_period(2)) @(negedge clk);
    begin
      bit f1;
      int h1, q1;
      highs = 0;
      fork
        for (int n = 0; n < 3 * exp_period(0); n++) begin
          @(negedge clk);
          if (blink[0]) highs++;
        end
        grab(1, f1, h1, q1);
      join
      check_eq("R4", "duty 0 stays dark", highs, 0);
      check_eq("R6", "ch1 period beside dark ch0", q1, exp_period(0));
      check_eq("R6", "ch1 high beside dark ch0", h1, exp_high(0, 128));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule